// File: doc/BRIEF.md
# Debug Register Access Responder

This block is an endpoint on a packet-based debug network. Requests arrive as an ordered stream of 16-bit flits under a valid/ready handshake, and a last flag closes each packet. Flit 0 is the destination, flit 1 the requester's address, and flit 2 carries the packet class in bits [15:14] and the operation code in bits [13:10]. Flit 3 is the register address, and any payload flits follow it. The block serves only the register-access class (class 0). It performs the read or write on a small local register file and returns a response packet on a second flit stream.

The operation code combines a direction with an access width. Codes 0 to 3 are reads and codes 4 to 7 are writes, with the low two bits w selecting 1, 2, 4 or 8 flits (16, 32, 64 or 128 bits). A wide access touches consecutive 16-bit registers. Address A holds the most significant flit, so payload or data flit k maps to address A+k. The register file holds five base words at addresses 0..4: vendor, module type, version, control/status and event destination. The first three are read-only parameter constants. It also holds N_USER module-specific words starting at address 512.

Packets of any other class, and register packets that end before their address flit, are consumed without a response. The input is stalled from the last flit of a served request until the last flit of its response has been accepted.

Top module: `dbg_reg_responder`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: A packet whose class field (flit 2 bits [15:14]) is not 0, or a class-0 packet of fewer than 4 flits, is fully consumed. It produces no response and changes no register.
- R3: A read (code 0..3, w = code[1:0]) with no payload, whose 2^w addresses A..A+2^w-1 all map to registers, is answered with 3+2^w flits. Flit 0 is the requester's address, flit 1 is MOD_ADDR and flit 2 holds class 0 with code 8+w in bits [13:10], zero elsewhere. Flit 3+k is the register at A+k, and out_last_o marks the final flit.
- R4: Addresses 0, 1 and 2 read back the VENDOR_ID, TYPE_ID and VERSION_ID parameters.
- R5: A write (code 4..7) with exactly 2^w payload flits, all targets mapped and none at addresses 0..2, stores payload flit k into address A+k. It is answered with 3 flits carrying code 14.
- R6: A write whose target range touches address 0..2 or an unmapped address, or whose payload count differs from 2^w, is answered with 3 flits carrying code 15 and changes no register.
- R7: A read with any payload flit, or with an unmapped address in its range, is answered with 3 flits carrying code 12.
- R8: A request with code 8..15, including the undefined code 13, is answered with 3 flits carrying code 12. No response ever carries code 13.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_data_o and out_last_o hold. in_ready_o stays 0 from the accepted last flit of a served request until the last response flit is accepted.
- R10: Any pattern of idle cycles on in_valid_i within a packet, and of stalls on out_ready_i, leaves the flit sequences unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request flit valid |
| in_ready_o | output | 1 | Request flit accepted when high with valid |
| in_data_i | input | 16 | Request flit |
| in_last_i | input | 1 | Final flit of the request packet |
| out_valid_o | output | 1 | Response flit valid |
| out_ready_i | input | 1 | Downstream accepts the response flit |
| out_data_o | output | 16 | Response flit |
| out_last_o | output | 1 | Final flit of the response packet |

## Verification
The assertions make no assumption about out_ready_i: the hold property on the output must survive arbitrary stalls, and the bench draws the stall pattern from a pseudo-random sequence. The assertions also take for granted that the request stream never interleaves two packets, because the block parses flits purely by position since the previous last flag. The stimulus always sends one complete packet and then collects its response before it starts the next. The bench drops valid at random between flits, but it never changes a flit that is valid and has not yet been accepted.

// File: rtl/dbg_resp_pkg.sv
package dbg_resp_pkg;
  localparam int FLIT_W = 16;
  localparam int MAX_PL = 8;             // 128-bit access in 16-bit flits
  localparam int PL_CW  = 4;             // counts up to MAX_PL+1
  localparam int PL_IW  = $clog2(MAX_PL);

  localparam logic [1:0] CLS_REG    = 2'd0;
  localparam logic [3:0] SUB_RD_ERR = 4'd12;
  localparam logic [3:0] SUB_WR_OK  = 4'd14;
  localparam logic [3:0] SUB_WR_ERR = 4'd15;

  typedef logic [FLIT_W-1:0] flit_t;

  typedef struct packed {
    flit_t            src;
    logic [1:0]       cls;
    logic [3:0]       sub;
    flit_t            addr;
    logic [PL_CW-1:0] pl_cnt;
  } req_t;
endpackage

// File: rtl/dbg_req_rx.sv
module dbg_req_rx
  import dbg_resp_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  flit_t                   in_data_i,
  input  logic                    in_last_i,
  input  logic                    done_i,
  output logic                    start_o,
  output req_t                    req_o,
  output flit_t [MAX_PL-1:0]      buf_o
);
  logic [2:0]          pos_q;   // 0..3 header, 4 payload
  req_t                req_q;
  flit_t [MAX_PL-1:0]  buf_q;
  logic                busy_q, start_q;
  logic                acc;

  assign in_ready_o = !busy_q;
  assign acc        = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      req_q   <= '0;
      buf_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (done_i) busy_q <= 1'b0;
      if (acc) begin
        case (pos_q)
          3'd0: ;
          3'd1: req_q.src <= in_data_i;
          3'd2: begin
            req_q.cls <= in_data_i[15:14];
            req_q.sub <= in_data_i[13:10];
          end
          3'd3: begin
            req_q.addr   <= in_data_i;
            req_q.pl_cnt <= '0;
          end
          default: begin
            if (req_q.pl_cnt < PL_CW'(MAX_PL))
              buf_q[req_q.pl_cnt[PL_IW-1:0]] <= in_data_i;
            if (req_q.pl_cnt <= PL_CW'(MAX_PL))
              req_q.pl_cnt <= req_q.pl_cnt + 1'b1;
          end
        endcase
        if (in_last_i) begin
          pos_q <= '0;
          if (pos_q >= 3'd3 && req_q.cls == CLS_REG) begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
          end
        end else if (pos_q != 3'd4) begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign start_o = start_q;
  assign req_o   = req_q;
  assign buf_o   = buf_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q && !in_ready_o); // R9
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_resp_pkg::*;
#(
  parameter int          N_USER     = 8,
  parameter int          USER_BASE  = 512,
  parameter logic [15:0] VENDOR_ID  = 16'h0001,
  parameter logic [15:0] TYPE_ID    = 16'h0001,
  parameter logic [15:0] VERSION_ID = 16'h0001
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  flit_t                   waddr_i,
  input  logic [PL_CW-1:0]        wcnt_i,
  input  flit_t [MAX_PL-1:0]      wdata_i,
  input  flit_t                   raddr_i,
  output flit_t                   rdata_o
);
  localparam int AW = FLIT_W + 1;

  flit_t               cs_q, evd_q;
  flit_t [N_USER-1:0]  user_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '0;
      evd_q  <= '0;
      user_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < MAX_PL; k++) begin
        if (PL_CW'(k) < wcnt_i) begin
          if ({1'b0, waddr_i} + AW'(k) == AW'(3)) cs_q  <= wdata_i[k];
          if ({1'b0, waddr_i} + AW'(k) == AW'(4)) evd_q <= wdata_i[k];
          for (int j = 0; j < N_USER; j++)
            if ({1'b0, waddr_i} + AW'(k) == AW'(USER_BASE + j)) user_q[j] <= wdata_i[k];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      16'd0: rdata_o = VENDOR_ID;
      16'd1: rdata_o = TYPE_ID;
      16'd2: rdata_o = VERSION_ID;
      16'd3: rdata_o = cs_q;
      16'd4: rdata_o = evd_q;
      default: begin
        for (int j = 0; j < N_USER; j++)
          if (raddr_i == FLIT_W'(USER_BASE + j)) rdata_o = user_q[j];
      end
    endcase
  end

  AST_WR_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i >= 16'd3 && {1'b0, waddr_i} + AW'(wcnt_i) <= AW'(5)) ||
             (waddr_i >= FLIT_W'(USER_BASE) &&
              {1'b0, waddr_i} + AW'(wcnt_i) <= AW'(USER_BASE + N_USER))); // R6
endmodule

// File: rtl/dbg_resp_tx.sv
module dbg_resp_tx
  import dbg_resp_pkg::*;
#(
  parameter logic [15:0] MOD_ADDR = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  flit_t             dst_i,
  input  logic [3:0]        sub_i,
  input  logic [PL_CW-1:0]  ndata_i,
  input  flit_t             base_addr_i,
  input  flit_t             rdata_i,
  output flit_t             raddr_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output flit_t             out_data_o,
  output logic              out_last_o,
  output logic              done_o
);
  logic             active_q;
  logic [PL_CW-1:0] idx_q;
  logic [PL_CW-1:0] last_idx;

  assign last_idx = PL_CW'(2) + ndata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q && out_ready_i) begin
      if (idx_q == last_idx) active_q <= 1'b0;
      else                   idx_q    <= idx_q + 1'b1;
    end
  end

  assign raddr_o     = base_addr_i + FLIT_W'(idx_q) - FLIT_W'(3);
  assign out_valid_o = active_q;
  assign out_last_o  = active_q && idx_q == last_idx;
  assign done_o      = active_q && out_ready_i && idx_q == last_idx;

  always_comb begin
    case (idx_q)
      PL_CW'(0): out_data_o = dst_i;
      PL_CW'(1): out_data_o = MOD_ADDR;
      PL_CW'(2): out_data_o = {2'b00, sub_i, 10'h000};
      default:   out_data_o = rdata_i;
    endcase
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R9
  AST_SUB_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && idx_q == PL_CW'(2) |-> sub_i[3] && sub_i != 4'd13); // R8
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R9
endmodule

// File: rtl/dbg_reg_responder.sv
module dbg_reg_responder
  import dbg_resp_pkg::*;
#(
  parameter logic [15:0] MOD_ADDR   = 16'h0021,
  parameter int          N_USER     = 8,
  parameter int          USER_BASE  = 512,
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] TYPE_ID    = 16'h0007,
  parameter logic [15:0] VERSION_ID = 16'h0003
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [15:0] in_data_i,
  input  logic        in_last_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [15:0] out_data_o,
  output logic        out_last_o
);
  localparam int AW       = FLIT_W + 1;
  localparam int USER_END = USER_BASE + N_USER - 1;

  req_t               req;
  flit_t [MAX_PL-1:0] pl_buf;
  logic               start, done;
  flit_t              raddr, rdata;

  logic [PL_CW-1:0]   n_fl, ndata;
  logic [AW-1:0]      lo, hi;
  logic               is_rd, is_wr, map_ok, len_ok, ro_hit, acc_ok, we;
  logic [3:0]         rsp_sub;

  dbg_req_rx u_rx (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_data_i, .in_last_i,
    .done_i (done), .start_o (start), .req_o (req), .buf_o (pl_buf)
  );

  // request decode, held stable by the receiver while busy
  always_comb begin
    n_fl    = PL_CW'(1) << req.sub[1:0];
    lo      = {1'b0, req.addr};
    hi      = lo + AW'(n_fl) - AW'(1);
    is_rd   = req.sub[3:2] == 2'b00;
    is_wr   = req.sub[3:2] == 2'b01;
    map_ok  = (hi <= AW'(4)) || (lo >= AW'(USER_BASE) && hi <= AW'(USER_END));
    ro_hit  = lo <= AW'(2);
    len_ok  = is_rd ? (req.pl_cnt == '0) : (req.pl_cnt == n_fl);
    acc_ok  = req.cls == CLS_REG && (is_rd || is_wr) && map_ok && len_ok && !(is_wr && ro_hit);
    if (is_wr) rsp_sub = acc_ok ? SUB_WR_OK : SUB_WR_ERR;
    else       rsp_sub = acc_ok ? {2'b10, req.sub[1:0]} : SUB_RD_ERR;
    ndata   = (is_rd && acc_ok) ? n_fl : '0;
    we      = start && is_wr && acc_ok;
  end

  dbg_regfile #(
    .N_USER (N_USER), .USER_BASE (USER_BASE),
    .VENDOR_ID (VENDOR_ID), .TYPE_ID (TYPE_ID), .VERSION_ID (VERSION_ID)
  ) u_rf (
    .clk_i, .rst_ni,
    .we_i (we), .waddr_i (req.addr), .wcnt_i (n_fl), .wdata_i (pl_buf),
    .raddr_i (raddr), .rdata_o (rdata)
  );

  dbg_resp_tx #(.MOD_ADDR (MOD_ADDR)) u_tx (
    .clk_i, .rst_ni,
    .start_i (start), .dst_i (req.src), .sub_i (rsp_sub), .ndata_i (ndata),
    .base_addr_i (req.addr), .rdata_i (rdata), .raddr_o (raddr),
    .out_valid_o, .out_ready_i, .out_data_o, .out_last_o, .done_o (done)
  );

  AST_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R9
  AST_WR_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> !out_valid_o); // R5
endmodule

// File: tb/dbg_reg_responder_tb_top.sv
module dbg_reg_responder_tb_top;
  localparam logic [15:0] MOD = 16'h0021;
  localparam logic [15:0] VEN = 16'h1A2B;
  localparam logic [15:0] TYP = 16'h0007;
  localparam logic [15:0] VER = 16'h0003;
  localparam int NU = 8;
  localparam int UB = 512;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, in_last = 0;
  logic [15:0] in_data = 0;
  logic out_valid, out_ready = 0, out_last;
  logic [15:0] out_data;

  always #2.5 clk = ~clk;

  dbg_reg_responder dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .in_valid_i (in_valid), .in_ready_o (in_ready), .in_data_i (in_data), .in_last_i (in_last),
    .out_valid_o (out_valid), .out_ready_i (out_ready), .out_data_o (out_data), .out_last_o (out_last)
  );

  int checks = 0, errors = 0;
  logic [15:0] pkt [16];
  logic [15:0] rsp [16];
  logic [15:0] ex  [16];
  int rlen, elen;
  logic [15:0] m_cs = 0, m_evd = 0;
  logic [15:0] m_user [NU];
  logic [15:0] lfsr = 16'hACE1;
  int gap_pct = 30, stall_pct = 30;

  function bit coin(int pct);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr % 100) < pct;
  endfunction

  function bit mapped(int a);
    return (a >= 0 && a <= 4) || (a >= UB && a < UB + NU);
  endfunction

  function bit wrable(int a);
    return a == 3 || a == 4 || (a >= UB && a < UB + NU);
  endfunction

  function logic [15:0] mval(int a);
    case (a)
      0: return VEN;
      1: return TYP;
      2: return VER;
      3: return m_cs;
      4: return m_evd;
      default: return (a >= UB && a < UB + NU) ? m_user[a - UB] : 16'h0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(int n);
    for (int i = 0; i < n; i++) begin
      do begin
        @(negedge clk);
        if (coin(gap_pct)) in_valid = 0;
        else begin
          in_valid = 1; in_data = pkt[i]; in_last = (i == n - 1);
        end
      end while (!(in_valid && in_ready));
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic recv();
    int t = 0;
    bit hold_bad = 0, rdy_bad = 0, pend = 0, fin = 0;
    logic [15:0] pd; logic pl;
    rlen = 0;
    while (!fin) begin
      @(negedge clk);
      t++;
      if (t > 1000) begin
        checks++; errors++;
        $display("FAIL R3 response timeout actual=%0d expected=%0d", rlen, elen);
        out_ready = 0;
        return;
      end
      if (pend && (!out_valid || out_data != pd || out_last != pl)) hold_bad = 1;
      if (out_valid && in_ready) rdy_bad = 1;
      pend = 0;
      out_ready = !coin(stall_pct);
      if (out_valid) begin
        if (out_ready) begin
          rsp[rlen] = out_data;
          if (rlen < 15) rlen++;
          if (out_last) fin = 1;
        end else begin
          pend = 1; pd = out_data; pl = out_last;
        end
      end
    end
    @(negedge clk);
    out_ready = 0;
    check("R9", hold_bad, 0, "output changed while stalled");
    check("R9", rdy_bad, 0, "input ready during response");
  endtask

  task automatic cmp(string tag);
    checks++;
    if (rlen != elen) begin
      errors++;
      $display("FAIL %s response length actual=%0d expected=%0d", tag, rlen, elen);
      return;
    end
    for (int i = 0; i < elen; i++)
      if (rsp[i] !== ex[i]) begin
        errors++;
        $display("FAIL %s flit %0d actual=%0h expected=%0h", tag, i, rsp[i], ex[i]);
        return;
      end
  endtask

  task automatic do_read(int a, int w, int extra);
    int n = 1 << w;
    bit ok = (extra == 0);
    pkt[0] = MOD; pkt[1] = 16'h0300 ^ 16'(a); pkt[2] = {2'b00, 4'(w), 10'h0}; pkt[3] = 16'(a);
    for (int i = 0; i < extra; i++) pkt[4 + i] = 16'hDEAD;
    for (int k = 0; k < n; k++) if (!mapped(a + k)) ok = 0;
    ex[0] = pkt[1]; ex[1] = MOD; ex[2] = {2'b00, ok ? 4'(8 + w) : 4'd12, 10'h0};
    elen = 3;
    if (ok) for (int k = 0; k < n; k++) begin ex[3 + k] = mval(a + k); elen++; end
    send(4 + extra);
    recv();
    cmp(ok ? "R3" : "R7");
  endtask

  task automatic do_write(int a, int w, int npl);
    int n = 1 << w;
    bit ok = (npl == n);
    pkt[0] = MOD; pkt[1] = 16'h0500 ^ 16'(a); pkt[2] = {2'b00, 4'(4 + w), 10'h0}; pkt[3] = 16'(a);
    for (int i = 0; i < npl; i++) pkt[4 + i] = 16'hA000 ^ 16'(a << 4) ^ 16'(i) ^ 16'(w << 10);
    for (int k = 0; k < n; k++) if (!wrable(a + k)) ok = 0;
    if (ok) for (int k = 0; k < n; k++) begin
      if (a + k == 3) m_cs = pkt[4 + k];
      else if (a + k == 4) m_evd = pkt[4 + k];
      else m_user[a + k - UB] = pkt[4 + k];
    end
    ex[0] = pkt[1]; ex[1] = MOD; ex[2] = {2'b00, ok ? 4'd14 : 4'd15, 10'h0};
    elen = 3;
    send(4 + npl);
    recv();
    cmp(ok ? "R5" : "R6");
  endtask

  task automatic quiet(string tag);
    bit seen = 0;
    repeat (40) @(negedge clk) if (out_valid) seen = 1;
    check(tag, seen, 0, "response to dropped packet");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < NU; j++) m_user[j] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1", in_ready, 1, "in_ready after reset");
    check("R1", out_valid, 0, "out_valid after reset");

    do_read(0, 0, 0); check("R4", rsp[3], VEN, "vendor");
    do_read(1, 0, 0); check("R4", rsp[3], TYP, "type");
    do_read(2, 0, 0); check("R4", rsp[3], VER, "version");

    // address and width sweep across both mapped windows and their edges
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 24; i++) begin
        int a = (i < 8) ? i : 500 + i;
        do_write(a, w, 1 << w);
        do_read(a, w, 0);
      end

    // payload length mismatches
    do_write(UB, 2, 3);
    do_write(UB, 2, 5);
    do_write(UB, 0, 0);
    do_write(UB, 3, 10);
    do_write(3, 1, 1);
    do_read(UB, 3, 0);
    do_read(UB, 1, 1);
    do_read(3, 0, 2);

    // response-class and undefined codes used as requests
    for (int s = 8; s < 16; s++) begin
      pkt[0] = MOD; pkt[1] = 16'h0700 + 16'(s); pkt[2] = {2'b00, 4'(s), 10'h0}; pkt[3] = 16'd3;
      send(4);
      recv();
      ex[0] = pkt[1]; ex[1] = MOD; ex[2] = {2'b00, 4'd12, 10'h0}; elen = 3;
      cmp("R8");
    end

    // dropped packets: foreign classes and truncated register packets
    for (int c = 1; c < 4; c++) begin
      pkt[0] = MOD; pkt[1] = 16'h0900; pkt[2] = {2'(c), 4'd4, 10'h0}; pkt[3] = 16'd3; pkt[4] = 16'hBEEF;
      send(5);
      quiet("R2");
      do_read(3, 0, 0);
      check("R2", rsp[3], m_cs, "register after dropped write");
    end
    pkt[0] = MOD; pkt[1] = 16'h0901; pkt[2] = 16'h0000;
    send(3); quiet("R2");
    send(1); quiet("R2");
    do_read(0, 0, 0);

    // heavy gaps and stalls
    gap_pct = 80; stall_pct = 85;
    do_write(UB, 3, 8);
    do_read(UB, 3, 0);
    check("R10", rlen, 11, "flit count under gaps");
    do_read(0, 2, 0);
    gap_pct = 0; stall_pct = 0;
    do_read(UB + 4, 2, 0);
    check("R10", rlen, 7, "flit count without gaps");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule